// File: doc/BRIEF.md
# MSI Vector Interrupt Aggregator

This block gathers message-signalled interrupts that arrive as inbound memory writes and turns them into eight interrupt lines for a local processor. Each inbound write carries a vector number in its data word. The block records the vector as a pending bit in one of eight status registers. The vectors are interleaved: the low three bits of the vector choose the register, and the next two bits choose the bit inside it. Thirty-two vectors are supported.

Software uses a simple register port to manage the block. It reads the pending bits, clears them by writing ones, sets and clears per-bit enables, and writes an end-of-interrupt code. Each output line gives a one-cycle pulse when its register holds an enabled pending bit. The line then stays quiet until software writes the end-of-interrupt code that belongs to it. End-of-interrupt codes 0 to 3 are kept for four other interrupt sources. A line's own code is its index plus 4.

Top module: `msi_vec_agg`

## Requirements
- R1: After reset, all status bits, all enable bits, every `irq_line` bit and `vec_overflow` are 0.
- R2: An inbound write of vector v (`msi_data` < 32) sets bit v/8 of status register v mod 8. Status register r is read at address 0x104 + 16·r, and its bits appear in `reg_rdata[3:0]`.
- R3: A register write to a status address clears each pending bit whose `reg_wdata` bit is 1. Bits written with 0 keep their value.
- R4: Writing to 0x108 + 16·r sets the enable bits of register r that are 1 in `reg_wdata[3:0]`. Writing to 0x10C + 16·r clears them. A read from either address returns the enable bits of register r in `reg_rdata[3:0]`.
- R5: Line n gives a pulse of exactly one cycle when register n has a pending bit that is also enabled and no end-of-interrupt is outstanding for line n. A pending bit that is not enabled never causes a pulse.
- R6: After a pulse, line n stays low until a register write to address 0x050 carries the value n + 4. Other values, including the reserved values 0 to 3 and codes for other lines, have no effect on line n.
- R7: After its end-of-interrupt, line n pulses again if an enabled pending bit is still set. It stays low if that bit was cleared first.
- R8: When an inbound write and a write-one-to-clear reach the same status bit in the same cycle, the bit ends up set. Other bits named in the clear are still cleared.
- R9: An inbound vector of 32 or more changes no status bit and sets `vec_overflow`. The flag stays set until reset.
- R10: `reg_rdata` holds the value read one clock after the cycle in which `reg_rd` is high. Addresses that are not mapped, and the end-of-interrupt address, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | Inbound message write strobe |
| msi_data | input | 32 | Inbound message data word: the vector number |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| irq_line | output | 8 | Per-register interrupt pulses |
| vec_overflow | output | 1 | Sticky flag for out-of-range vectors |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle. They also assume that the inputs are held stable for a whole cycle around each rising edge. The bench drives every input on the falling edge and raises only one register strobe at a time, so both assumptions always hold. The only overlap the bench creates on purpose is an inbound write together with a status clear in the same cycle. The set-wins assertion is written to cover exactly that case.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int NREG   = 8;
  localparam int NBIT   = 4;
  localparam int NVEC   = NREG * NBIT;
  localparam int IDXW   = $clog2(NREG);
  localparam int BITW   = $clog2(NBIT);
  localparam int AW     = 12;
  localparam int DW     = 32;
  localparam int STRIDE_SH = 4;
  localparam int EOI_LINE_BASE = 4;
  localparam logic [AW-1:0] WIN_BASE = 12'h100;
  localparam logic [AW-1:0] WIN_END  = WIN_BASE + AW'(NREG << STRIDE_SH);
  localparam logic [AW-1:0] EOI_ADDR = 12'h050;

  typedef enum logic [1:0] {K_NONE, K_STAT, K_ENSET, K_ENCLR} reg_kind_e;

  typedef struct packed {
    reg_kind_e       kind;
    logic [IDXW-1:0] idx;
  } reg_sel_t;

  function automatic logic vec_in_range(input logic [DW-1:0] v);
    return v < DW'(NVEC);
  endfunction

  function automatic logic [IDXW-1:0] vec_reg(input logic [DW-1:0] v);
    return v[IDXW-1:0];
  endfunction

  function automatic logic [BITW-1:0] vec_bit(input logic [DW-1:0] v);
    return v[IDXW +: BITW];
  endfunction

  function automatic reg_sel_t decode_addr(input logic [AW-1:0] a);
    reg_sel_t s;
    logic [AW-1:0] off;
    s.kind = K_NONE;
    s.idx  = '0;
    off    = a - WIN_BASE;
    if (a >= WIN_BASE && a < WIN_END) begin
      s.idx = off[STRIDE_SH +: IDXW];
      case (off[STRIDE_SH-1:0])
        4'h4:    s.kind = K_STAT;
        4'h8:    s.kind = K_ENSET;
        4'hC:    s.kind = K_ENCLR;
        default: s.kind = K_NONE;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/msi_vec_capture.sv
module msi_vec_capture
  import msi_agg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      msi_valid,
  input  logic [DW-1:0]             msi_data,
  output logic [NREG-1:0][NBIT-1:0] set_mask,
  output logic                      ovf_flag
);
  logic in_range;
  logic bad_vec;

  assign in_range = vec_in_range(msi_data);
  assign bad_vec  = msi_valid && !in_range;

  always_comb begin
    set_mask = '0;
    if (msi_valid && in_range)
      set_mask[vec_reg(msi_data)][vec_bit(msi_data)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (bad_vec) ovf_flag <= 1'b1;
  end

  assert_big_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_vec |-> ($countones(set_mask) == 0));
  assert_single_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_mask));
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);
endmodule

// File: rtl/msi_regfile.sv
module msi_regfile
  import msi_agg_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NREG-1:0][NBIT-1:0] set_mask,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [AW-1:0]             reg_addr,
  input  logic [DW-1:0]             reg_wdata,
  output logic [DW-1:0]             reg_rdata,
  output logic [NREG-1:0]           req_any,
  output logic [NREG-1:0]           eoi_hit
);
  logic [NREG-1:0][NBIT-1:0] pend;
  logic [NREG-1:0][NBIT-1:0] en;
  logic [NREG-1:0][NBIT-1:0] clr_mask;
  logic [NREG-1:0][NBIT-1:0] ens_mask;
  logic [NREG-1:0][NBIT-1:0] enc_mask;
  reg_sel_t                  sel;
  logic                      eoi_wr;

  assign sel    = decode_addr(reg_addr);
  assign eoi_wr = reg_wr && (reg_addr == EOI_ADDR);

  for (genvar n = 0; n < NREG; n++) begin : g_reg
    assign clr_mask[n] = (reg_wr && sel.kind == K_STAT  && sel.idx == IDXW'(n)) ? reg_wdata[NBIT-1:0] : '0;
    assign ens_mask[n] = (reg_wr && sel.kind == K_ENSET && sel.idx == IDXW'(n)) ? reg_wdata[NBIT-1:0] : '0;
    assign enc_mask[n] = (reg_wr && sel.kind == K_ENCLR && sel.idx == IDXW'(n)) ? reg_wdata[NBIT-1:0] : '0;
    assign req_any[n]  = |(pend[n] & en[n]);
    assign eoi_hit[n]  = eoi_wr && (reg_wdata == DW'(n + EOI_LINE_BASE));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      en   <= '0;
    end else begin
      pend <= (pend & ~clr_mask) | set_mask;
      en   <= (en | ens_mask) & ~enc_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (sel.kind)
        K_STAT:          reg_rdata <= {{(DW-NBIT){1'b0}}, pend[sel.idx]};
        K_ENSET, K_ENCLR: reg_rdata <= {{(DW-NBIT){1'b0}}, en[sel.idx]};
        default:         reg_rdata <= '0;
      endcase
    end
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask) |=> ((pend & $past(set_mask)) == $past(set_mask)));
  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~set_mask)) |=> ((pend & $past(clr_mask & ~set_mask)) == '0));
  assert_strobes_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_any,
  input  logic eoi,
  output logic irq_pulse
);
  logic outst;
  logic fire;

  assign fire = req_any && !outst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst     <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= fire;
      if (fire)     outst <= 1'b1;
      else if (eoi) outst <= 1'b0;
    end
  end

  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  assert_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(req_any));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (outst && !eoi) |=> !irq_pulse);
endmodule

// File: rtl/msi_vec_agg.sv
module msi_vec_agg
  import msi_agg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            msi_valid,
  input  logic [DW-1:0]   msi_data,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic [NREG-1:0] irq_line,
  output logic            vec_overflow
);
  logic [NREG-1:0][NBIT-1:0] set_mask;
  logic [NREG-1:0]           req_any;
  logic [NREG-1:0]           eoi_hit;

  msi_vec_capture u_cap (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_data(msi_data),
    .set_mask(set_mask), .ovf_flag(vec_overflow)
  );

  msi_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req_any(req_any), .eoi_hit(eoi_hit)
  );

  for (genvar n = 0; n < NREG; n++) begin : g_line
    msi_line_ctrl u_line (
      .clk(clk), .rst_n(rst_n), .req_any(req_any[n]), .eoi(eoi_hit[n]),
      .irq_pulse(irq_line[n])
    );
  end

  assert_lines_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (irq_line == '0 && !vec_overflow));
endmodule

// File: tb/msi_vec_agg_test.sv
module msi_vec_agg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msi_valid = 1'b0;
  logic [31:0] msi_data = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  irq_line;
  logic        vec_overflow;

  int total = 0;
  int bad = 0;
  int pulses [8];
  bit done = 0;

  always #4 clk = ~clk;

  msi_vec_agg uut (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_data(msi_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_line(irq_line), .vec_overflow(vec_overflow)
  );

  always @(negedge clk)
    for (int i = 0; i < 8; i++) if (irq_line[i]) pulses[i]++;

  function automatic logic [11:0] stat_a(input int r);  return 12'(32'h104 + 16*r); endfunction
  function automatic logic [11:0] enset_a(input int r); return 12'(32'h108 + 16*r); endfunction
  function automatic logic [11:0] enclr_a(input int r); return 12'(32'h10C + 16*r); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic msi(input logic [31:0] v);
    @(negedge clk); msi_valid = 1; msi_data = v;
    @(negedge clk); msi_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int r = 0; r < 8; r++) begin
      rd(stat_a(r), d); check("R1 status", d, 0);
      rd(enset_a(r), d); check("R1 enable", d, 0);
    end
    check("R1 lines", {24'd0, irq_line}, 0);
    check("R1 overflow", {31'd0, vec_overflow}, 0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    msi(13); msi(0); msi(31);
    rd(stat_a(5), d); check("R2 vec13", d, 32'h2);
    rd(stat_a(0), d); check("R2 vec0", d, 32'h1);
    rd(stat_a(7), d); check("R2 vec31", d, 32'h8);
    rd(stat_a(1), d); check("R2 untouched", d, 32'h0);
    idle(3);
    for (int i = 0; i < 8; i++) check("R5 disabled no pulse", pulses[i], 0);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr(stat_a(5), 32'h2);
    rd(stat_a(5), d); check("R3 clear", d, 0);
    wr(stat_a(0), 32'h0);
    rd(stat_a(0), d); check("R3 zero keeps", d, 32'h1);
    wr(stat_a(0), 32'h1); wr(stat_a(7), 32'h8);
    rd(stat_a(0), d); check("R3 clear r0", d, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(enset_a(2), 32'h5);
    rd(enset_a(2), d); check("R4 set read", d, 32'h5);
    rd(enclr_a(2), d); check("R4 alias read", d, 32'h5);
    wr(enclr_a(2), 32'h4);
    rd(enset_a(2), d); check("R4 clear", d, 32'h1);
    wr(enclr_a(2), 32'h1);
  endtask

  task automatic t_pulse;
    logic [31:0] d;
    wr(enset_a(3), 32'h1);
    msi(3); idle(3);
    check("R5 pulse line3", pulses[3], 1);
    msi(3); idle(3);
    check("R6 held without eoi", pulses[3], 1);
    wr(12'h050, 3); idle(3);
    check("R6 reserved eoi", pulses[3], 1);
    wr(12'h050, 8); idle(3);
    check("R6 other line eoi", pulses[3], 1);
    wr(12'h050, 7); idle(3);
    check("R7 refire after eoi", pulses[3], 2);
    wr(stat_a(3), 32'h1);
    wr(12'h050, 7); idle(3);
    check("R7 no refire when cleared", pulses[3], 2);
    rd(12'h050, d); check("R10 eoi reads zero", d, 0);
    for (int i = 0; i < 8; i++) if (i != 3) check("R5 other lines quiet", pulses[i], 0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    msi(4);
    @(negedge clk); msi_valid = 1; msi_data = 20;
    reg_wr = 1; reg_addr = stat_a(4); reg_wdata = 32'h5;
    @(negedge clk); msi_valid = 0; reg_wr = 0;
    rd(stat_a(4), d); check("R8 set wins", d, 32'h4);
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    msi(32); msi(40);
    check("R9 flag", {31'd0, vec_overflow}, 1);
    rd(stat_a(0), d); check("R9 no status r0", d, 0);
    msi(1);
    check("R9 sticky", {31'd0, vec_overflow}, 1);
    rd(stat_a(1), d); check("R2 vec1", d, 32'h1);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(12'h300, d); check("R10 unmapped", d, 0);
    rd(12'h100, d); check("R10 hole", d, 0);
    @(negedge clk); reg_rd = 1; reg_addr = stat_a(4);
    @(negedge clk); reg_rd = 0; reg_addr = 12'h300;
    check("R10 latency", reg_rdata, 32'h4);
  endtask

  initial begin
    idle(4);
    rst_n = 1;
    idle(1);
    t_reset();
    t_map();
    t_w1c();
    t_enable();
    t_pulse();
    t_set_wins();
    t_overflow();
    t_unmapped();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule